// File: doc/BRIEF.md
# Dual-Clock FIFO With Selectable Flag Timing

This block is a 36-bit first-in first-out buffer with separate write and read clocks. The two clocks may be unrelated or may be the same net. A write and a read on the same edge are both allowed. The write and read pointers cross between the clock domains as Gray code through two-flop synchronizers. The write domain computes the full and almost-full status, and the read domain computes the empty and almost-empty status.

The timing style is captured from `fwft_sel` while master reset is held. In standard style, the read-side flag means "empty" and the write-side flag means "full", and a word reaches `dout` only after an explicit read. In fall-through style, the read-side flag means "a word is presented" and the write-side flag means "room for another word". The oldest word moves to `dout` without any read request.

Two threshold offsets drive the almost-empty and almost-full outputs. A master reset loads both offsets from one of three defaults. Either offset can later be replaced, either by a serial bit stream or by a parallel load. A partial reset empties the buffer but keeps the timing style and both offsets.

Top module: `dcfifo_flagmode`

## Requirements
- R1: After a master reset the buffer holds no data. In standard style `rd_flag`=1 and `wr_flag`=0. In fall-through style `rd_flag`=0 and `wr_flag`=1.
- R2: In standard style, a read with `rd_en`=1 sampled on an `rclk` edge while the buffer is not empty places the oldest word on `dout` at that edge. Words leave in the order they were written.
- R3: In standard style `wr_flag` (full) is 1 exactly when DEPTH words are stored. In either style a write while the memory is full is ignored.
- R4: In standard style a read while empty is ignored: `dout` keeps its value and no word is lost or duplicated afterwards.
- R5: In fall-through style the oldest word appears on `dout` with `rd_flag`=1 and no read. A read on an edge where `rd_flag`=1 consumes it. The total capacity is DEPTH+1 words, and `wr_flag` (ready) is 0 when the memory behind the output stage holds DEPTH words.
- R6: `almost_empty` is 1 when the number of stored words is at or below the empty offset. In fall-through style the presented word counts as stored.
- R7: `almost_full` is 1 when DEPTH minus the memory word count is at or below the full offset. In fall-through style the presented word is not part of the memory count.
- R8: While master reset is held, `def_sel` chooses both offsets: 0 gives 8, 1 gives 16, 2 gives 64, and 3 gives 8.
- R9: With `ser_mode`=1, each `wclk` edge with `ser_en`=1 shifts in `ser_din`. The first OW bits form the empty offset and the next OW bits form the full offset, each least significant bit first. `pgm_en` is ignored in this mode.
- R10: With `ser_mode`=0, a `wclk` edge with `pgm_en`=1 loads `pgm_data` into the empty offset when `pgm_sel`=0, or into the full offset when `pgm_sel`=1.
- R11: A partial reset empties the buffer and restores the flags of R1, but keeps the timing style and both offsets.
- R12: Changes on `fwft_sel` after master reset has been released have no effect.
- R13: With one common clock, a read and a write on every edge keep the data stream in order with no loss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| mrst_n | input | 1 | Master reset, asynchronous, active low |
| prst_n | input | 1 | Partial reset, asynchronous, active low |
| fwft_sel | input | 1 | Timing style captured at master reset (1 = fall-through) |
| def_sel | input | 2 | Default offset choice captured at master reset |
| wr_en | input | 1 | Write request |
| din | input | 36 | Write data |
| wr_flag | output | 1 | Full (standard) or ready-for-input (fall-through) |
| almost_full | output | 1 | Free space at or below the full offset |
| rd_en | input | 1 | Read request |
| dout | output | 36 | Read data |
| rd_flag | output | 1 | Empty (standard) or word-presented (fall-through) |
| almost_empty | output | 1 | Stored words at or below the empty offset |
| ser_mode | input | 1 | 1 = serial offset loading, 0 = parallel |
| ser_en | input | 1 | Serial shift enable |
| ser_din | input | 1 | Serial offset bit |
| pgm_en | input | 1 | Parallel offset load strobe |
| pgm_sel | input | 1 | Parallel target: 0 empty offset, 1 full offset |
| pgm_data | input | OW | Parallel offset value |

## Verification
The assertions take two things for granted. First, the offsets are quasi-static: they are changed only while the buffer is idle, because the read domain uses them without synchronization. Second, `fwft_sel` and `def_sel` are steady during the last cycles of master reset. The bench loads offsets only with no traffic in flight, and it changes `fwft_sel` only while reset is held or well after release. Flags are compared only after enough idle cycles for both pointer synchronizers to settle. The one exception is the back-to-back read/write run, which keeps the fill level far from both limits so that the flag lag cannot block a transfer.

// File: rtl/dcf_pkg.sv
`timescale 1ns/1ps
package dcf_pkg;
  localparam int DATA_W = 36;

  typedef enum logic [1:0] {
    DEF_8  = 2'd0,
    DEF_16 = 2'd1,
    DEF_64 = 2'd2,
    DEF_8B = 2'd3
  } def_sel_e;
endpackage

// File: rtl/dcf_rst_sync.sv
`timescale 1ns/1ps
module dcf_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_ok
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_ok = stage_q[1];
endmodule

// File: rtl/dcf_gsync.sv
`timescale 1ns/1ps
module dcf_gsync #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_ok,
  input  logic [W-1:0] gray_in,
  output logic [W-1:0] bin_out
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= gray_in;
      s2_q <= s1_q;
    end
  end

  for (genvar i = 0; i < W; i++) begin : g_g2b
    assign bin_out[i] = ^(s2_q >> i);
  end
endmodule

// File: rtl/dcf_offset_cfg.sv
`timescale 1ns/1ps
module dcf_offset_cfg #(
  parameter int OW = 10
) (
  input  logic          clk,
  input  logic          m_ok,
  input  logic [1:0]    def_sel,
  input  logic          ser_mode,
  input  logic          ser_en,
  input  logic          ser_din,
  input  logic          pgm_en,
  input  logic          pgm_sel,
  input  logic [OW-1:0] pgm_data,
  output logic [OW-1:0] ae_off,
  output logic [OW-1:0] af_off
);
  import dcf_pkg::*;

  logic [2*OW-1:0] off_q, off_d;
  logic [OW-1:0]   dflt;
  logic            shift_go, load_go;

  always_comb begin
    case (def_sel_e'(def_sel))
      DEF_16:  dflt = OW'(16);
      DEF_64:  dflt = OW'(64);
      default: dflt = OW'(8);
    endcase
    shift_go = ser_mode && ser_en;
    load_go  = !ser_mode && pgm_en;
    off_d    = off_q;
    if (!m_ok)         off_d = {dflt, dflt};
    else if (shift_go) off_d = {ser_din, off_q[2*OW-1:1]};
    else if (load_go) begin
      if (pgm_sel) off_d[2*OW-1:OW] = pgm_data;
      else         off_d[OW-1:0]    = pgm_data;
    end
  end

  always_ff @(posedge clk) begin
    off_q <= off_d;
  end

  assign ae_off = off_q[OW-1:0];
  assign af_off = off_q[2*OW-1:OW];

  // R9 R10
  offsets_idle_chk: assert property (@(posedge clk) disable iff (!m_ok)
    (!(ser_mode && ser_en) && !(!ser_mode && pgm_en)) |=> ($stable(ae_off) && $stable(af_off)));
endmodule

// File: rtl/dcf_rd_side.sv
`timescale 1ns/1ps
module dcf_rd_side #(
  parameter int DEPTH = 512,
  parameter int AW    = 9,
  parameter int OW    = 10,
  parameter int DW    = 36
) (
  input  logic          rclk,
  input  logic          c_ok,
  input  logic          fwft,
  input  logic          rd_en,
  input  logic [AW:0]   wbin_s,
  input  logic [OW-1:0] ae_off,
  input  logic [DW-1:0] mem_rd,
  output logic [AW-1:0] raddr,
  output logic [AW:0]   rgray,
  output logic [DW-1:0] dout,
  output logic          rd_flag,
  output logic          almost_empty
);
  logic [AW:0]   rbin_q, rbin_d, rgray_d, rcnt;
  logic [AW+1:0] total;
  logic          ov_q, ov_d, fetch, mem_empty;
  logic [DW-1:0] dout_d;

  always_comb begin
    rcnt      = wbin_s - rbin_q;
    mem_empty = (rcnt == '0);
    if (fwft) fetch = !mem_empty && (!ov_q || rd_en);
    else      fetch = rd_en && !mem_empty;
    ov_d = ov_q;
    if (!fwft)       ov_d = 1'b0;
    else if (fetch)  ov_d = 1'b1;
    else if (rd_en)  ov_d = 1'b0;
    rbin_d  = fetch ? rbin_q + (AW+1)'(1) : rbin_q;
    rgray_d = rbin_d ^ (rbin_d >> 1);
    dout_d  = fetch ? mem_rd : dout;
    total   = {1'b0, rcnt} + {{(AW+1){1'b0}}, fwft & ov_q};
  end

  always_ff @(posedge rclk or negedge c_ok) begin
    if (!c_ok) begin
      rbin_q <= '0;
      rgray  <= '0;
      ov_q   <= 1'b0;
      dout   <= '0;
    end else begin
      rbin_q <= rbin_d;
      rgray  <= rgray_d;
      ov_q   <= ov_d;
      dout   <= dout_d;
    end
  end

  assign raddr        = rbin_q[AW-1:0];
  assign rd_flag      = fwft ? ov_q : mem_empty;
  assign almost_empty = 32'(total) <= 32'(ae_off);

  // R2
  no_underflow_chk: assert property (@(posedge rclk) disable iff (!c_ok)
    rcnt <= (AW+1)'(DEPTH));
  // R4
  empty_read_hold_chk: assert property (@(posedge rclk) disable iff (!c_ok)
    (!fwft && rd_en && mem_empty) |=> ($stable(dout) && $stable(rbin_q)));
  // R5
  presented_hold_chk: assert property (@(posedge rclk) disable iff (!c_ok)
    (fwft && ov_q && !rd_en) |=> (ov_q && $stable(dout)));
endmodule

// File: rtl/dcfifo_flagmode.sv
`timescale 1ns/1ps
module dcfifo_flagmode #(
  parameter int  DEPTH = 512,
  localparam int AW    = $clog2(DEPTH),
  localparam int OW    = (AW + 1 > 7) ? AW + 1 : 7,
  localparam int DW    = dcf_pkg::DATA_W
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          mrst_n,
  input  logic          prst_n,
  input  logic          fwft_sel,
  input  logic [1:0]    def_sel,
  input  logic          wr_en,
  input  logic [DW-1:0] din,
  output logic          wr_flag,
  output logic          almost_full,
  input  logic          rd_en,
  output logic [DW-1:0] dout,
  output logic          rd_flag,
  output logic          almost_empty,
  input  logic          ser_mode,
  input  logic          ser_en,
  input  logic          ser_din,
  input  logic          pgm_en,
  input  logic          pgm_sel,
  input  logic [OW-1:0] pgm_data
);
  logic          clr_n, m_ok_w, c_ok_w, m_ok_r, c_ok_r;
  logic          fwft_w, fwft_w_d, fwft_r, fwft_r_d;
  logic [AW:0]   wbin_q, wbin_d, wgray_q, wgray_d, rgray, rbin_s, wbin_s, wcnt, wfree;
  logic [AW-1:0] raddr;
  logic [OW-1:0] ae_off, af_off;
  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] mem_rd;
  logic          full, wr_go;

  assign clr_n = mrst_n & prst_n;

  dcf_rst_sync u_mrs_w (.clk(wclk), .arst_n(mrst_n), .rst_ok(m_ok_w));
  dcf_rst_sync u_clr_w (.clk(wclk), .arst_n(clr_n),  .rst_ok(c_ok_w));
  dcf_rst_sync u_mrs_r (.clk(rclk), .arst_n(mrst_n), .rst_ok(m_ok_r));
  dcf_rst_sync u_clr_r (.clk(rclk), .arst_n(clr_n),  .rst_ok(c_ok_r));

  // timing style: follows the pin only while master reset is in effect
  always_comb begin
    fwft_w_d = m_ok_w ? fwft_w : fwft_sel;
    fwft_r_d = m_ok_r ? fwft_r : fwft_sel;
  end
  always_ff @(posedge wclk) fwft_w <= fwft_w_d;
  always_ff @(posedge rclk) fwft_r <= fwft_r_d;

  dcf_offset_cfg #(.OW(OW)) u_cfg (
    .clk(wclk), .m_ok(m_ok_w), .def_sel(def_sel),
    .ser_mode(ser_mode), .ser_en(ser_en), .ser_din(ser_din),
    .pgm_en(pgm_en), .pgm_sel(pgm_sel), .pgm_data(pgm_data),
    .ae_off(ae_off), .af_off(af_off)
  );

  // write domain
  dcf_gsync #(.W(AW+1)) u_rsync (.clk(wclk), .rst_ok(c_ok_w), .gray_in(rgray), .bin_out(rbin_s));

  always_comb begin
    wcnt    = wbin_q - rbin_s;
    wfree   = (AW+1)'(DEPTH) - wcnt;
    full    = (wcnt == (AW+1)'(DEPTH));
    wr_go   = wr_en && !full;
    wbin_d  = wr_go ? wbin_q + (AW+1)'(1) : wbin_q;
    wgray_d = wbin_d ^ (wbin_d >> 1);
  end

  always_ff @(posedge wclk or negedge c_ok_w) begin
    if (!c_ok_w) begin
      wbin_q  <= '0;
      wgray_q <= '0;
    end else begin
      wbin_q  <= wbin_d;
      wgray_q <= wgray_d;
    end
  end

  always_ff @(posedge wclk) begin
    if (wr_go) mem[wbin_q[AW-1:0]] <= din;
  end

  assign wr_flag     = fwft_w ? !full : full;
  assign almost_full = 32'(wfree) <= 32'(af_off);

  // read domain
  dcf_gsync #(.W(AW+1)) u_wsync (.clk(rclk), .rst_ok(c_ok_r), .gray_in(wgray_q), .bin_out(wbin_s));

  assign mem_rd = mem[raddr];

  dcf_rd_side #(.DEPTH(DEPTH), .AW(AW), .OW(OW), .DW(DW)) u_rd (
    .rclk(rclk), .c_ok(c_ok_r), .fwft(fwft_r), .rd_en(rd_en),
    .wbin_s(wbin_s), .ae_off(ae_off), .mem_rd(mem_rd),
    .raddr(raddr), .rgray(rgray), .dout(dout),
    .rd_flag(rd_flag), .almost_empty(almost_empty)
  );

  // R3
  no_overflow_chk: assert property (@(posedge wclk) disable iff (!c_ok_w)
    wcnt <= (AW+1)'(DEPTH));
  // R3
  full_write_drop_chk: assert property (@(posedge wclk) disable iff (!c_ok_w)
    (wr_en && full) |=> $stable(wbin_q));
  // R12
  mode_hold_chk: assert property (@(posedge wclk) disable iff (!m_ok_w)
    m_ok_w |=> $stable(fwft_w));
endmodule

// File: tb/tb_dcfifo_flagmode.sv
`timescale 1ns/1ps
module tb_dcfifo_flagmode;
  localparam int DEPTH = 16;
  localparam int OW    = 7;

  logic          clk = 1'b0;
  logic          mrst_n, prst_n, fwft_sel, wr_en, rd_en;
  logic [1:0]    def_sel;
  logic [35:0]   din;
  logic          ser_mode, ser_en, ser_din, pgm_en, pgm_sel;
  logic [OW-1:0] pgm_data;
  logic          wr_flag, almost_full, rd_flag, almost_empty;
  logic [35:0]   dout;

  int nchk = 0;
  int nerr = 0;
  logic [35:0] q[$];

  always #2 clk = ~clk;

  dcfifo_flagmode #(.DEPTH(DEPTH)) dut (
    .wclk(clk), .rclk(clk), .mrst_n(mrst_n), .prst_n(prst_n),
    .fwft_sel(fwft_sel), .def_sel(def_sel),
    .wr_en(wr_en), .din(din), .wr_flag(wr_flag), .almost_full(almost_full),
    .rd_en(rd_en), .dout(dout), .rd_flag(rd_flag), .almost_empty(almost_empty),
    .ser_mode(ser_mode), .ser_en(ser_en), .ser_din(ser_din),
    .pgm_en(pgm_en), .pgm_sel(pgm_sel), .pgm_data(pgm_data)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic mreset(input logic fw, input logic [1:0] sel);
    mrst_n = 1'b0; fwft_sel = fw; def_sel = sel;
    q.delete();
    tick(3);
    mrst_n = 1'b1;
    tick(4);
  endtask

  task automatic push(input logic [35:0] d);
    wr_en = 1'b1; din = d;
    tick(1);
    wr_en = 1'b0;
  endtask

  task automatic pop();
    rd_en = 1'b1;
    tick(1);
    rd_en = 1'b0;
  endtask

  // settle, then compare all four flags against the arithmetic model
  task automatic flags(input string tag, input bit fw, input int aeo, input int afo);
    int n, mc;
    tick(7);
    n  = q.size();
    mc = (fw && n > 0) ? n - 1 : n;
    chk({tag, " R3/R5 wr_flag"}, 64'(wr_flag), fw ? 64'(mc < DEPTH) : 64'(mc == DEPTH));
    chk({tag, " R2/R5 rd_flag"}, 64'(rd_flag), fw ? 64'(n > 0) : 64'(n == 0));
    chk({tag, " R6 almost_empty"}, 64'(almost_empty), 64'(n <= aeo));
    chk({tag, " R7 almost_full"}, 64'(almost_full), 64'((DEPTH - mc) <= afo));
  endtask

  task automatic sweep(input string tag, input bit fw, input int aeo, input int afo, input int base);
    int cap;
    logic [35:0] d, last;
    cap = fw ? DEPTH + 1 : DEPTH;
    flags({tag, " start"}, fw, aeo, afo);
    for (int i = 0; i < cap; i++) begin
      d = 36'(base + i * 7 + 36'h5_0000_0000);
      push(d);
      q.push_back(d);
      flags({tag, " fill"}, fw, aeo, afo);
      if (fw && i == 0) chk({tag, " R5 head without read"}, 64'(dout), 64'(q[0]));
    end
    push(36'hF_FFFF_FFFF);                     // R3 write while full ignored
    flags({tag, " R3 overfill"}, fw, aeo, afo);
    last = '0;
    while (q.size() > 0) begin
      if (fw) begin
        chk({tag, " R5 presented word"}, 64'(dout), 64'(q[0]));
        pop();
        last = q.pop_front();
      end else begin
        pop();
        last = q.pop_front();
        chk({tag, " R2 read order"}, 64'(dout), 64'(last));
      end
      flags({tag, " drain"}, fw, aeo, afo);
    end
    pop();                                     // R4 read while empty ignored
    tick(4);
    if (!fw) chk({tag, " R4 dout held"}, 64'(dout), 64'(last));
    flags({tag, " R4 empty read"}, fw, aeo, afo);
    d = 36'(base + 36'h0_ABCD);
    push(d);
    tick(7);
    if (fw) begin
      chk({tag, " R4/R5 after empty read"}, 64'(dout), 64'(d));
      pop();
    end else begin
      pop();
      chk({tag, " R4 after empty read"}, 64'(dout), 64'(d));
    end
    flags({tag, " end"}, fw, aeo, afo);
  endtask

  initial begin
    #(4 * 100000);
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nerr);
    $finish;
  end

  initial begin
    logic [2*OW-1:0] sv;
    logic [35:0] d;
    mrst_n = 1'b0; prst_n = 1'b1; fwft_sel = 1'b0; def_sel = 2'd0;
    wr_en = 1'b0; rd_en = 1'b0; din = '0;
    ser_mode = 1'b0; ser_en = 1'b0; ser_din = 1'b0;
    pgm_en = 1'b0; pgm_sel = 1'b0; pgm_data = '0;
    tick(2);

    // R1 R8 standard style, default 8; R12 pin toggled after release
    mreset(1'b0, 2'd0);
    chk("R1 std empty", 64'(rd_flag), 64'd1);
    chk("R1 std not full", 64'(wr_flag), 64'd0);
    fwft_sel = 1'b1;
    sweep("R8/R12 std def8", 1'b0, 8, 8, 100);

    // R8 default 64 and 16 and code 3
    mreset(1'b0, 2'd2);
    sweep("R8 std def64", 1'b0, 64, 64, 300);
    mreset(1'b0, 2'd3);
    flags("R8 def code3", 1'b0, 8, 8);
    for (int i = 0; i < 9; i++) begin push(36'(i)); q.push_back(36'(i)); end
    flags("R8 def code3 nine", 1'b0, 8, 8);

    // R9 serial: empty offset 3 then full offset 5, LSB first
    mreset(1'b0, 2'd1);
    ser_mode = 1'b1;
    sv = {OW'(5), OW'(3)};
    for (int i = 0; i < 2 * OW; i++) begin
      ser_en = 1'b1; ser_din = sv[i];
      tick(1);
    end
    ser_en = 1'b0;
    pgm_en = 1'b1; pgm_sel = 1'b0; pgm_data = '0;   // R9 ignored while serial
    tick(1);
    pgm_en = 1'b0;
    sweep("R9 serial", 1'b0, 3, 5, 500);

    // R10 parallel: empty offset 10, full offset 2
    ser_mode = 1'b0;
    pgm_en = 1'b1; pgm_sel = 1'b0; pgm_data = OW'(10);
    tick(1);
    pgm_sel = 1'b1; pgm_data = OW'(2);
    tick(1);
    pgm_en = 1'b0;
    sweep("R10 parallel", 1'b0, 10, 2, 700);

    // R11 partial reset keeps offsets
    for (int i = 0; i < 5; i++) begin push(36'(i + 9)); end
    tick(6);
    prst_n = 1'b0; tick(2); prst_n = 1'b1; tick(4);
    q.delete();
    chk("R11 std empty after partial", 64'(rd_flag), 64'd1);
    sweep("R11 kept offsets", 1'b0, 10, 2, 900);

    // R13 simultaneous read and write on one clock
    for (int i = 0; i < 4; i++) begin
      d = 36'(36'h7_0000_0000 + i); push(d); q.push_back(d);
    end
    tick(7);
    for (int i = 0; i < 20; i++) begin
      d = 36'(36'h7_1000_0000 + i);
      wr_en = 1'b1; rd_en = 1'b1; din = d;
      tick(1);
      q.push_back(d);
      chk("R13 same-edge stream", 64'(dout), 64'(q.pop_front()));
    end
    wr_en = 1'b0; rd_en = 1'b0;
    flags("R13 after stream", 1'b0, 10, 2);
    while (q.size() > 0) begin
      pop();
      chk("R13 drain", 64'(dout), 64'(q.pop_front()));
    end

    // R1 R5 fall-through style, default 16; R12 pin toggled after release
    mreset(1'b1, 2'd1);
    chk("R1 fwft no word", 64'(rd_flag), 64'd0);
    chk("R1 fwft ready", 64'(wr_flag), 64'd1);
    fwft_sel = 1'b0;
    sweep("R5/R12 fwft def16", 1'b1, 16, 16, 1100);

    // R11 partial reset keeps fall-through style
    for (int i = 0; i < 3; i++) begin push(36'(i + 40)); end
    tick(6);
    prst_n = 1'b0; tick(2); prst_n = 1'b1; tick(4);
    q.delete();
    flags("R11 fwft after partial", 1'b1, 16, 16);
    d = 36'h3_3333_3333; push(d); q.push_back(d);
    flags("R11 fwft style kept", 1'b1, 16, 16);
    chk("R11 fwft head", 64'(dout), 64'(d));

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nerr);
    $finish;
  end
endmodule